// File: doc/BRIEF.md
# Station Address PROM Window

The block owns a 16-byte station address PROM placed at the bottom of a device's register window. A simple host bus presents an address, a size code giving the byte count, separate read and write strobes, and 32-bit write data. Accesses below offset 16 are decoded here, against the PROM. The widths that are legal there depend on a 32-bit I/O mode bit, and PROM writes also need a write-enable bit. Accesses at offset 16 and above with a 2- or 4-byte size go out unchanged to a separate register-port interface. That port's read data comes back on the same read bus.

Every read returns its data one clock after the read strobe, together with a valid flag. A read that matches no legal case returns all ones for the requested size. An illegal write does nothing. The two configuration bits sit in registers that load together on a single strobe and clear on reset. On reset the PROM is also loaded from a parameter.

Top module: `prom_window`

## Requirements
- R1: During and after reset, PROM byte i holds PROM_INIT[8i+7:8i], the 32-bit mode and write-enable bits read as clear, and busRdValid is low.
- R2: With 32-bit mode clear, a 1-byte access (size code 1) at any offset 0..15 is legal, and the byte is returned in bits 7:0 with the upper bits zero.
- R3: With 32-bit mode clear, a 2-byte access (size code 2) is legal only at an even offset below 16. It covers bytes a and a+1, with byte a in bits 7:0 and byte a+1 in bits 15:8.
- R4: With 32-bit mode set, only a 4-byte access (size code 4) at an offset below 16 that is a multiple of 4 is legal. It covers bytes a..a+3, with byte a+k in bits 8k+7:8k.
- R5: A legal PROM write changes the PROM only while the write-enable bit is set. Otherwise the PROM keeps its contents.
- R6: Any other access below offset 16 (wrong size for the mode, misaligned, or size codes 0, 3, 5..7) never changes the PROM. Its read returns 0xFF for size code 1, 0xFFFF for size code 2, and 0xFFFFFFFF for any other code.
- R7: At offset 16 and above, a size code of 2 or 4 raises fwdRd or fwdWr in the same cycle as the bus strobe, with fwdAddr, fwdSize and fwdWrData equal to the bus inputs. The read result is fwdRdData as sampled at that edge.
- R8: At offset 16 and above, any other size code raises no forward strobe. Its read returns all ones as in R6.
- R9: busRdValid is high, and busRdData holds the result, exactly in the cycle after a cycle with busRd high. busRdValid is low otherwise.
- R10: cfgLoad high at a clock edge loads cfgWideIn into the 32-bit mode bit and cfgWeIn into the write-enable bit. Otherwise both bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset into the window |
| busSize | input | 3 | Byte count of the access (1, 2 or 4) |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 32 | Write data, lowest addressed byte in bits 7:0 |
| busRdData | output | 32 | Registered read data |
| busRdValid | output | 1 | Read data valid, one cycle after busRd |
| cfgLoad | input | 1 | Load strobe for the two configuration bits |
| cfgWideIn | input | 1 | New value of the 32-bit I/O mode bit |
| cfgWeIn | input | 1 | New value of the PROM write-enable bit |
| fwdRd | output | 1 | Read strobe to the register port |
| fwdWr | output | 1 | Write strobe to the register port |
| fwdAddr | output | ADDR_W | Address passed to the register port |
| fwdSize | output | 3 | Size code passed to the register port |
| fwdWrData | output | 32 | Write data passed to the register port |
| fwdRdData | input | 32 | Register port read data, valid in the strobe cycle |

## Verification
The bench builds the block with ADDR_W = 6 and a PROM_INIT in which every byte is distinct. This keeps the forwarded region to offsets 16..63, and it makes a swapped lane, a wrong byte index or a stray write show up as a wrong value. The bench sweeps every combination of mode bit, write-enable bit, size code 1 to 4 and offset 0..19, with a write followed by a read each time, and finally reads the whole PROM back byte by byte. This exposes any illegal access that changed storage or raised a forward strobe.

// File: rtl/prom_window_pkg.sv
package prom_window_pkg;

  // Strobes from the decode to the storage side.
  typedef struct packed {
    logic       promRd;    // legal PROM read
    logic       promWr;    // legal, enabled PROM write
    logic       fwdRd;     // forwarded read
    logic [1:0] lastLane;  // highest byte lane touched (0, 1 or 3)
  } winCtlT;

  localparam int unsigned PROM_BYTES = 16;
  localparam int unsigned BUS_BYTES  = 4;

endpackage

// File: rtl/prom_window_ctrl.sv
module prom_window_ctrl
  import prom_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              cfgLoad,
  input  logic              cfgWideIn,
  input  logic              cfgWeIn,
  output winCtlT            ctl,
  output logic              fwdWr
);

  localparam int unsigned LOW_W = $clog2(PROM_BYTES);

  logic wideQ;
  logic weQ;
  logic inProm;
  logic legalProm;
  logic fwdOk;

  // R10: configuration bits load together on one strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideQ <= 1'b0;
      weQ   <= 1'b0;
    end else if (cfgLoad) begin
      wideQ <= cfgWideIn;
      weQ   <= cfgWeIn;
    end
  end

  always_comb begin
    inProm    = (addr[ADDR_W-1:LOW_W] == '0);
    legalProm = (!wideQ && size == 3'd1)
             || (!wideQ && size == 3'd2 && !addr[0])
             || ( wideQ && size == 3'd4 && addr[1:0] == 2'b00);
    fwdOk     = !inProm && (size == 3'd2 || size == 3'd4);

    ctl.promRd   = rdEn && inProm && legalProm;
    ctl.promWr   = wrEn && inProm && legalProm && weQ;
    ctl.fwdRd    = rdEn && fwdOk;
    ctl.lastLane = (size == 3'd4) ? 2'd3 : (size == 3'd2) ? 2'd1 : 2'd0;
    fwdWr        = wrEn && fwdOk;
  end

  // R10: without a load strobe the configuration holds
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> ($stable(wideQ) && $stable(weQ)));

  // R7/R8: forwarding never overlaps a PROM access
  a_r8_no_fwd_in_prom: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.promRd || ctl.promWr) |-> !(ctl.fwdRd || fwdWr));

  // R5: a PROM write needs the enable set at an earlier edge
  a_r5_write_enabled: assert property (@(posedge clk) disable iff (!rstN)
    ctl.promWr |-> weQ);

endmodule

// File: rtl/prom_window_data.sv
module prom_window_data
  import prom_window_pkg::*;
#(
  parameter logic [8*PROM_BYTES-1:0] PROM_INIT = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  idx,
  input  logic [2:0]  size,
  input  logic        rdEn,
  input  logic [31:0] wrData,
  input  logic [31:0] fwdRdData,
  input  winCtlT      ctl,
  output logic [31:0] rdData,
  output logic        rdValid
);

  logic [7:0]              prom [PROM_BYTES];
  logic [8*PROM_BYTES-1:0] promVec;
  logic [31:0]             promWord;
  logic [31:0]             onesWord;

  // storage: R1 reset load, R5 gated byte-lane writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PROM_BYTES; i++) prom[i] <= PROM_INIT[8*i +: 8];
    end else if (ctl.promWr) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (k <= int'(ctl.lastLane)) prom[4'(idx + 4'(k))] <= wrData[8*k +: 8];
      end
    end
  end

  // byte lane assembly, little-endian, unused lanes zero
  always_comb begin
    promWord = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (k <= int'(ctl.lastLane)) promWord[8*k +: 8] = prom[4'(idx + 4'(k))];
    end
    onesWord = (size == 3'd1) ? 32'h0000_00FF :
               (size == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  end

  generate
    for (genvar g = 0; g < PROM_BYTES; g++) begin : g_vec
      assign promVec[8*g +: 8] = prom[g];
    end
  endgenerate

  // R9: registered read result, one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= ctl.promRd ? promWord : ctl.fwdRd ? fwdRdData : onesWord;
    end
  end

  // R5/R6: storage only moves on a granted write
  a_r6_prom_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.promWr |=> $stable(promVec));

  // R9: valid follows the read strobe by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  a_r9_valid_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

endmodule

// File: rtl/prom_window.sv
module prom_window
  import prom_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [8*PROM_BYTES-1:0] PROM_INIT =
    {8'h57, 8'h57, {8{8'h00}}, 8'h56, 8'h34, 8'h12, 8'h00, 8'h54, 8'h52}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              busRdValid,
  input  logic              cfgLoad,
  input  logic              cfgWideIn,
  input  logic              cfgWeIn,
  output logic              fwdRd,
  output logic              fwdWr,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [2:0]        fwdSize,
  output logic [31:0]       fwdWrData,
  input  logic [31:0]       fwdRdData
);

  winCtlT ctl;

  prom_window_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .size(busSize),
    .rdEn(busRd), .wrEn(busWr), .cfgLoad(cfgLoad),
    .cfgWideIn(cfgWideIn), .cfgWeIn(cfgWeIn), .ctl(ctl), .fwdWr(fwdWr)
  );

  prom_window_data #(.PROM_INIT(PROM_INIT)) i_data (
    .clk(clk), .rstN(rstN), .idx(busAddr[3:0]), .size(busSize),
    .rdEn(busRd), .wrData(busWrData), .fwdRdData(fwdRdData), .ctl(ctl),
    .rdData(busRdData), .rdValid(busRdValid)
  );

  assign fwdRd     = ctl.fwdRd;
  assign fwdAddr   = busAddr;
  assign fwdSize   = busSize;
  assign fwdWrData = busWrData;

endmodule

// File: tb/test_prom_window.sv
module test_prom_window;

  localparam int unsigned AW = 6;

  function automatic logic [127:0] mkInit();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'(8'h30 + i * 8'h13);
    return v;
  endfunction
  localparam logic [127:0] INIT = mkInit();

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [2:0]    busSize = 3'd1;
  logic          busRd = 1'b0, busWr = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          busRdValid;
  logic          cfgLoad = 1'b0, cfgWideIn = 1'b0, cfgWeIn = 1'b0;
  logic          fwdRd, fwdWr;
  logic [AW-1:0] fwdAddr;
  logic [2:0]    fwdSize;
  logic [31:0]   fwdWrData, fwdRdData;

  assign fwdRdData = 32'h5A5A_0000 | 32'(fwdAddr);

  prom_window #(.ADDR_W(AW), .PROM_INIT(INIT)) i_prom_window (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize),
    .busRd(busRd), .busWr(busWr), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid),
    .cfgLoad(cfgLoad), .cfgWideIn(cfgWideIn), .cfgWeIn(cfgWeIn),
    .fwdRd(fwdRd), .fwdWr(fwdWr), .fwdAddr(fwdAddr), .fwdSize(fwdSize),
    .fwdWrData(fwdWrData), .fwdRdData(fwdRdData)
  );

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0;
  int checks = 0;
  logic [7:0] model [16];
  bit mWide = 0, mWe = 0;
  logic [31:0] expQ [$];
  string tagQ [$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(int a, int sz);
    return a < 16 && ((!mWide && sz == 1) || (!mWide && sz == 2 && a % 2 == 0)
                      || (mWide && sz == 4 && a % 4 == 0));
  endfunction

  function automatic bit fwdCase(int a, int sz);
    return a >= 16 && (sz == 2 || sz == 4);
  endfunction

  function automatic logic [31:0] ones(int sz);
    return sz == 1 ? 32'hFF : sz == 2 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] expRead(int a, int sz);
    logic [31:0] v = '0;
    if (legal(a, sz)) begin
      for (int k = 0; k < sz; k++) v[8*k +: 8] = model[(a + k) % 16];
      return v;
    end
    if (fwdCase(a, sz)) return 32'h5A5A_0000 | 32'(a);
    return ones(sz);
  endfunction

  function automatic string reqOf(int a, int sz);
    if (a >= 16) return fwdCase(a, sz) ? "R7" : "R8";
    if (!legal(a, sz)) return "R6";
    return sz == 1 ? "R2" : sz == 2 ? "R3" : "R4";
  endfunction

  // R10: load both configuration bits
  task automatic setCfg(bit w, bit e);
    @(negedge clk);
    cfgLoad = 1; cfgWideIn = w; cfgWeIn = e;
    @(negedge clk);
    cfgLoad = 0; cfgWideIn = !w; cfgWeIn = !e;
    mWide = w; mWe = e;
  endtask

  task automatic access(bit isWr, int a, int sz, logic [31:0] d);
    bit f;
    @(negedge clk);
    busAddr = AW'(a); busSize = 3'(sz); busWrData = d;
    busRd = !isWr; busWr = isWr;
    f = fwdCase(a, sz);
    if (!isWr) begin
      expQ.push_back(expRead(a, sz));
      tagQ.push_back({reqOf(a, sz), "/R9"});
    end
    #2;
    chk(fwdRd == (!isWr && f) && fwdWr == (isWr && f), f ? "R7" : "R8",
        "forward strobes", {30'b0, fwdRd, fwdWr}, {30'b0, !isWr && f, isWr && f});
    if (f) chk(fwdAddr == AW'(a) && fwdSize == 3'(sz) && fwdWrData == d, "R7",
               "forward pass-through", fwdWrData, d);
    if (isWr && legal(a, sz) && mWe)
      for (int k = 0; k < sz; k++) model[(a + k) % 16] = d[8*k +: 8];
    @(negedge clk);
    busRd = 0; busWr = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busRdValid) begin
        if (expQ.size() == 0) chk(0, "R9", "valid without read", 32'(busRdValid), 0);
        else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(busRdData == e, t, "read data", busRdData, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = INIT[8*i +: 8];
    repeat (3) @(negedge clk);
    chk(busRdValid == 0, "R1", "valid in reset", 32'(busRdValid), 0);
    rstN = 1;
    @(negedge clk);
    chk(busRdValid == 0, "R1", "valid after reset", 32'(busRdValid), 0);
    // R1: reset contents, narrow mode and write disable in effect
    for (int a = 0; a < 16; a++) access(0, a, 1, 0);
    access(1, 0, 1, 32'hEE);  // R5: dropped, write enable clear
    access(0, 0, 1, 0);
    access(0, 2, 4, 0);        // R1/R6: wide access illegal after reset
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 2; e++) begin
        setCfg(bit'(w), bit'(e));
        for (int sz = 1; sz <= 4; sz++)
          for (int a = 0; a < 20; a++) begin
            access(1, a, sz, 32'hC3A5_1E00 ^ 32'(a * 32'h0107_0B0D + sz * 32'h11 + w * 4 + e));
            access(0, a, sz, 0);
          end
      end
    access(0, 20, 0, 0);  // R8: size code 0 high
    access(0, 5, 7, 0);   // R6: size code 7 low
    setCfg(0, 0);
    for (int a = 0; a < 16; a++) access(0, a, 1, 0);  // R5/R6 final contents
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R9", "reads left without result", 32'(expQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule